// File: doc/BRIEF.md
# Two-Port Synchronous RAM with Cross-Port Forwarding

This block is a synchronous memory with two fully independent access ports, X and Y. Each port has its own address, write data, write strobe and forwarding control. One rising clock edge captures every request input. In any cycle a port can read the array, write the array, or send its own captured write data straight to the other port's output, bypassing the array. Results are pipelined, so a request captured at one edge shows up on the output after the following edge, together with a valid flag.

When both ports name the same word in one cycle, fixed rules settle the outcome. Two reads both return the stored word. A read beside a write returns the contents from before the write. Two writes keep only the Y port's data. Forwarding has priority over reading: while either forwarding control is active, neither port reads the array.

Each port has a combinational active-low output enable that masks its result. Data in and data out are kept as separate buses. The depth and the word width are parameters. The default depth is kept small for elaboration, and the address width can be raised to 15 to give a 32K-word array.

Top module: `xy_relay_ram`

## Requirements
- R1: The block is selected only when `sel_n`=0 and `sel`=1. In any other combination the captured request writes nothing, and both valid flags are 0 after the next edge.
- R2: A read is captured when the port's `*_wr_n`=1 and both `*_fwd_n`=1. The word is on `*_dout`, with `*_vld`=1, after the edge that follows the capturing edge.
- R3: A write is captured when the port's `*_wr_n`=0. It stores `*_din` at `*_addr`, and a later read from either port returns that word.
- R4: `x_fwd_n`=0 sends port X's captured `x_din` to `y_dout`, with `y_vld`=1, one edge after capture.
- R5: `y_fwd_n`=0 sends port Y's captured `y_din` to `x_dout`, with `x_vld`=1, one edge after capture.
- R6: While either forwarding control is 0, neither port reads. A port that receives no forwarded data shows `*_vld`=0 and `*_dout`=0.
- R7: Two reads of the same address both return the stored word.
- R8: If one port writes an address and the other port reads it in the same cycle, the reader returns the word from before the write.
- R9: If both ports write the same address in the same cycle, only `y_din` is stored.
- R10: A cycle that leads to no read result and no forwarded result on a port (a write, or a deselect) clears that port's `*_vld` to 0 and `*_dout` to 0 after the next edge.
- R11: While `*_oe_n`=1, that port shows `*_vld`=0 and `*_dout`=0. When `*_oe_n` falls, the registered result appears at once, with no clock edge needed.
- R12: A synchronous `rst_n`=0 clears both output registers and both valid flags. The array keeps its contents.
- R13: Writes and forwarding can be combined in one cycle. For example, port X can write a word and forward the same data to port Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Select, active low |
| sel | input | 1 | Select, active high |
| x_addr | input | ADDR_W | Port X address |
| x_din | input | DATA_W | Port X write and forward data |
| x_wr_n | input | 1 | Port X write strobe, active low |
| x_fwd_n | input | 1 | Forward X data to port Y, active low |
| x_oe_n | input | 1 | Port X output enable, active low, combinational |
| x_dout | output | DATA_W | Port X result |
| x_vld | output | 1 | Port X result valid |
| y_addr | input | ADDR_W | Port Y address |
| y_din | input | DATA_W | Port Y write and forward data |
| y_wr_n | input | 1 | Port Y write strobe, active low |
| y_fwd_n | input | 1 | Forward Y data to port X, active low |
| y_oe_n | input | 1 | Port Y output enable, active low, combinational |
| y_dout | output | DATA_W | Port Y result |
| y_vld | output | 1 | Port Y result valid |

## Verification
The memory is observed only through later reads, so a lost or misdirected write shows up first on the next read of that address. That read's result appears two edges after it is driven. A collision rule that resolves the wrong way shows as the wrong word after a double write, or as new data after a same-cycle read-write pair, when the reading port's result is sampled. A broken forwarding or priority decode shows one edge after capture, as a valid flag on the wrong port or as array data where forwarded data was expected. The stimulus therefore pairs every collision and forwarding cycle with an immediate readback.

// File: rtl/xyr_pkg.sv
// Package: operation decoded for one port in one cycle.
// Assumes: the decoder is the only producer of these fields.
package xyr_pkg;
    typedef struct packed {
        logic wr;        // commit a write to the array
        logic rd;        // load array data into the output register
        logic take_peer; // load the peer port's captured data
    } port_op_t;
endpackage

// File: rtl/xyr_decode.sv
// Decoder: turns the captured request of both ports into per-port operations.
// Assumes: inputs come from the input registers.
// Forwarding suppresses reads on both ports. On equal write addresses, Y wins.
module xyr_decode
    import xyr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              en,
    input  logic              x_wr_n,
    input  logic              y_wr_n,
    input  logic              x_fwd_n,
    input  logic              y_fwd_n,
    input  logic [ADDR_W-1:0] x_addr,
    input  logic [ADDR_W-1:0] y_addr,
    output port_op_t          x_op,
    output port_op_t          y_op
);
    logic any_fwd;
    logic same_addr;

    // Purpose: derive the priority and collision terms, then the operations.
    always_comb begin
        any_fwd        = !x_fwd_n || !y_fwd_n;
        same_addr      = (x_addr == y_addr);
        y_op.wr        = en && !y_wr_n;
        x_op.wr        = en && !x_wr_n && !(y_op.wr && same_addr);
        x_op.rd        = en && x_wr_n && !any_fwd;
        y_op.rd        = en && y_wr_n && !any_fwd;
        x_op.take_peer = en && !y_fwd_n;
        y_op.take_peer = en && !x_fwd_n;
    end
endmodule

// File: rtl/xyr_array.sv
// Storage: two write ports and two combinational read ports.
// Assumes: the decoder never enables both writes on one address.
// Reads return the contents from before this edge's writes.
module xyr_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              x_we,
    input  logic [ADDR_W-1:0] x_addr,
    input  logic [DATA_W-1:0] x_wdata,
    input  logic              y_we,
    input  logic [ADDR_W-1:0] y_addr,
    input  logic [DATA_W-1:0] y_wdata,
    output logic [DATA_W-1:0] x_rdata,
    output logic [DATA_W-1:0] y_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: commit the enabled writes at the clock edge.
    always_ff @(posedge clk) begin
        if (x_we) mem[x_addr] <= x_wdata;
        if (y_we) mem[y_addr] <= y_wdata;
    end

    // Purpose: asynchronous read from both address ports.
    always_comb begin
        x_rdata = mem[x_addr];
        y_rdata = mem[y_addr];
    end

    // R9 / R3: a Y write is always present in the array after the edge.
    p_y_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        y_we |=> (mem[$past(y_addr)] == $past(y_wdata)));

    // R3: an X write is stored unless Y hit the same word.
    p_x_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (x_we && !(y_we && (y_addr == x_addr))) |=>
            (mem[$past(x_addr)] == $past(x_wdata)));
endmodule

// File: rtl/xyr_outstage.sv
// Output register for one port: holds the array word or the peer's data, with a valid flag.
// Assumes: rd and take_peer are never both set. Without either, the register clears.
module xyr_outstage
    import xyr_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_op_t          op,
    input  logic [DATA_W-1:0] arr_data,
    input  logic [DATA_W-1:0] peer_data,
    output logic [DATA_W-1:0] data_q,
    output logic              vld_q
);
    // Purpose: capture the selected result, or clear on write, deselect or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            vld_q  <= 1'b0;
        end else if (op.take_peer) begin
            data_q <= peer_data;
            vld_q  <= 1'b1;
        end else if (op.rd) begin
            data_q <= arr_data;
            vld_q  <= 1'b1;
        end else begin
            data_q <= '0;
            vld_q  <= 1'b0;
        end
    end

    // R6: read and forward are exclusive on one port.
    p_rd_fwd_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(op.rd && op.take_peer));

    // R10: a cycle with nothing to show clears the register.
    p_idle_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!op.rd && !op.take_peer) |=> (!vld_q && data_q == '0));
endmodule

// File: rtl/xy_relay_ram.sv
// Top: input registers, decoder, array, two output stages and output-enable masking.
// Assumes: every request input is sampled at the rising edge. Only the output enables are combinational.
module xy_relay_ram
    import xyr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sel,
    input  logic [ADDR_W-1:0] x_addr,
    input  logic [DATA_W-1:0] x_din,
    input  logic              x_wr_n,
    input  logic              x_fwd_n,
    input  logic              x_oe_n,
    output logic [DATA_W-1:0] x_dout,
    output logic              x_vld,
    input  logic [ADDR_W-1:0] y_addr,
    input  logic [DATA_W-1:0] y_din,
    input  logic              y_wr_n,
    input  logic              y_fwd_n,
    input  logic              y_oe_n,
    output logic [DATA_W-1:0] y_dout,
    output logic              y_vld
);
    localparam int NPORT = 2;

    logic              en_q;
    logic              x_wr_n_q, y_wr_n_q, x_fwd_n_q, y_fwd_n_q;
    logic [ADDR_W-1:0] x_addr_q, y_addr_q;
    logic [DATA_W-1:0] x_din_q, y_din_q;

    port_op_t          ops      [NPORT];
    logic [DATA_W-1:0] arr_rd   [NPORT];
    logic [DATA_W-1:0] peer     [NPORT];
    logic [DATA_W-1:0] res_data [NPORT];
    logic              res_vld  [NPORT];
    logic              oe_n     [NPORT];

    // Purpose: capture the control inputs; reset leaves them idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            x_wr_n_q  <= 1'b1;
            y_wr_n_q  <= 1'b1;
            x_fwd_n_q <= 1'b1;
            y_fwd_n_q <= 1'b1;
        end else begin
            en_q      <= !sel_n && sel;
            x_wr_n_q  <= x_wr_n;
            y_wr_n_q  <= y_wr_n;
            x_fwd_n_q <= x_fwd_n;
            y_fwd_n_q <= y_fwd_n;
        end
    end

    // Purpose: capture addresses and data; no reset is needed.
    always_ff @(posedge clk) begin
        x_addr_q <= x_addr;
        y_addr_q <= y_addr;
        x_din_q  <= x_din;
        y_din_q  <= y_din;
    end

    xyr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .en      (en_q),
        .x_wr_n  (x_wr_n_q),
        .y_wr_n  (y_wr_n_q),
        .x_fwd_n (x_fwd_n_q),
        .y_fwd_n (y_fwd_n_q),
        .x_addr  (x_addr_q),
        .y_addr  (y_addr_q),
        .x_op    (ops[0]),
        .y_op    (ops[1])
    );

    xyr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .x_we    (ops[0].wr),
        .x_addr  (x_addr_q),
        .x_wdata (x_din_q),
        .y_we    (ops[1].wr),
        .y_addr  (y_addr_q),
        .y_wdata (y_din_q),
        .x_rdata (arr_rd[0]),
        .y_rdata (arr_rd[1])
    );

    // Purpose: route each port's peer data and output enable.
    always_comb begin
        peer[0] = y_din_q;
        peer[1] = x_din_q;
        oe_n[0] = x_oe_n;
        oe_n[1] = y_oe_n;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        xyr_outstage #(.DATA_W(DATA_W)) u_out (
            .clk       (clk),
            .rst_n     (rst_n),
            .op        (ops[p]),
            .arr_data  (arr_rd[p]),
            .peer_data (peer[p]),
            .data_q    (res_data[p]),
            .vld_q     (res_vld[p])
        );
    end

    // Purpose: combinational output-enable masking of data and valid.
    always_comb begin
        x_vld  = res_vld[0] && !oe_n[0];
        y_vld  = res_vld[1] && !oe_n[1];
        x_dout = x_vld ? res_data[0] : '0;
        y_dout = y_vld ? res_data[1] : '0;
    end

    // R1: a deselected cycle leaves both results invalid.
    p_deselect_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (!res_vld[0] && !res_vld[1]));

    // R2: a captured X read is valid after the next edge.
    p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && x_wr_n_q && x_fwd_n_q && y_fwd_n_q) |=> res_vld[0]);

    // R4: X to Y forwarding delivers the captured X data.
    p_fwd_x_to_y_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !x_fwd_n_q) |=> (res_vld[1] && res_data[1] == $past(x_din_q)));

    // R5: Y to X forwarding delivers the captured Y data.
    p_fwd_y_to_x_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !y_fwd_n_q) |=> (res_vld[0] && res_data[0] == $past(y_din_q)));

    // R6: forwarding X to Y suppresses any X read.
    p_fwd_blocks_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !x_fwd_n_q && y_fwd_n_q) |=> !res_vld[0]);
endmodule

// File: tb/xy_relay_ram_tb.sv
module xy_relay_ram_tb;
    localparam int AW = 10;
    localparam int DW = 36;

    typedef struct packed {
        logic          e1n;
        logic          e2;
        logic [AW-1:0] xa;
        logic [DW-1:0] xd;
        logic          xw;
        logic          xf;
        logic [AW-1:0] ya;
        logic [DW-1:0] yd;
        logic          yw;
        logic          yf;
        logic          exv;
        logic [DW-1:0] exd;
        logic          eyv;
        logic [DW-1:0] eyd;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        // R3 R10: write X@5, write Y@6, both results cleared
        '{1'b0,1'b1,10'd5,36'h0A1,1'b0,1'b1,10'd6,36'h0B2,1'b0,1'b1,1'b0,36'h0,1'b0,36'h0,8'd10},
        // R2 R3: read X@5 and Y@6
        '{1'b0,1'b1,10'd5,36'h0,1'b1,1'b1,10'd6,36'h0,1'b1,1'b1,1'b1,36'h0A1,1'b1,36'h0B2,8'd2},
        // R7: both ports read address 5
        '{1'b0,1'b1,10'd5,36'h0,1'b1,1'b1,10'd5,36'h0,1'b1,1'b1,1'b1,36'h0A1,1'b1,36'h0A1,8'd7},
        // R8: X writes @5 while Y reads @5, Y sees old word
        '{1'b0,1'b1,10'd5,36'h0C3,1'b0,1'b1,10'd5,36'h0,1'b1,1'b1,1'b0,36'h0,1'b1,36'h0A1,8'd8},
        // R3: new word now visible
        '{1'b0,1'b1,10'd5,36'h0,1'b1,1'b1,10'd6,36'h0,1'b1,1'b1,1'b1,36'h0C3,1'b1,36'h0B2,8'd3},
        // R9: both write @7
        '{1'b0,1'b1,10'd7,36'h0D4,1'b0,1'b1,10'd7,36'h0E5,1'b0,1'b1,1'b0,36'h0,1'b0,36'h0,8'd9},
        // R9: Y data kept
        '{1'b0,1'b1,10'd7,36'h0,1'b1,1'b1,10'd7,36'h0,1'b1,1'b1,1'b1,36'h0E5,1'b1,36'h0E5,8'd9},
        // R4 R6: forward X to Y, both reads suppressed
        '{1'b0,1'b1,10'd5,36'hF6F6,1'b1,1'b0,10'd6,36'h0,1'b1,1'b1,1'b0,36'h0,1'b1,36'hF6F6,8'd4},
        // R5 R6: forward Y to X
        '{1'b0,1'b1,10'd5,36'h0,1'b1,1'b1,10'd6,36'h777,1'b1,1'b0,1'b1,36'h777,1'b0,36'h0,8'd5},
        // R4 R5: forward both directions
        '{1'b0,1'b1,10'd1,36'h111,1'b1,1'b0,10'd2,36'h222,1'b1,1'b0,1'b1,36'h222,1'b1,36'h111,8'd5},
        // R13: X writes @9 and forwards the same data to Y
        '{1'b0,1'b1,10'd9,36'h999,1'b0,1'b0,10'd3,36'h0,1'b1,1'b1,1'b0,36'h0,1'b1,36'h999,8'd13},
        // R13: write landed
        '{1'b0,1'b1,10'd9,36'h0,1'b1,1'b1,10'd9,36'h0,1'b1,1'b1,1'b1,36'h999,1'b1,36'h999,8'd13},
        // R1: sel_n high with writes, nothing happens
        '{1'b1,1'b1,10'd9,36'h5A5,1'b0,1'b1,10'd5,36'h5A5,1'b0,1'b1,1'b0,36'h0,1'b0,36'h0,8'd1},
        // R1: sel low with reads, no result
        '{1'b0,1'b0,10'd9,36'h0,1'b1,1'b1,10'd5,36'h0,1'b1,1'b1,1'b0,36'h0,1'b0,36'h0,8'd1},
        // R1: array unchanged after deselected writes
        '{1'b0,1'b1,10'd9,36'h0,1'b1,1'b1,10'd5,36'h0,1'b1,1'b1,1'b1,36'h999,1'b1,36'h0C3,8'd1},
        // R10: Y writes and X is deselected from reading (X writes too)
        '{1'b0,1'b1,10'd20,36'h1,1'b0,1'b1,10'd21,36'h2,1'b0,1'b1,1'b0,36'h0,1'b0,36'h0,8'd10}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sel_n, sel;
    logic [AW-1:0] x_addr, y_addr;
    logic [DW-1:0] x_din, y_din;
    logic          x_wr_n, x_fwd_n, x_oe_n, y_wr_n, y_fwd_n, y_oe_n;
    logic [DW-1:0] x_dout, y_dout;
    logic          x_vld, y_vld;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    xy_relay_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel),
        .x_addr(x_addr), .x_din(x_din), .x_wr_n(x_wr_n), .x_fwd_n(x_fwd_n),
        .x_oe_n(x_oe_n), .x_dout(x_dout), .x_vld(x_vld),
        .y_addr(y_addr), .y_din(y_din), .y_wr_n(y_wr_n), .y_fwd_n(y_fwd_n),
        .y_oe_n(y_oe_n), .y_dout(y_dout), .y_vld(y_vld)
    );

    task automatic check_port(string port, int req, logic av, logic [DW-1:0] ad,
                              logic ev, logic [DW-1:0] ed);
        n_checks++;
        if (av !== ev || ad !== ed) begin
            n_errors++;
            $display("FAIL R%0d port %s: vld=%0b data=%h, expected vld=%0b data=%h",
                     req, port, av, ad, ev, ed);
        end
    endtask

    task automatic set_idle();
        sel_n = 1'b1; sel = 1'b1;
        x_wr_n = 1'b1; x_fwd_n = 1'b1; y_wr_n = 1'b1; y_fwd_n = 1'b1;
    endtask

    task automatic drive(vec_t v);
        sel_n = v.e1n; sel = v.e2;
        x_addr = v.xa; x_din = v.xd; x_wr_n = v.xw; x_fwd_n = v.xf;
        y_addr = v.ya; y_din = v.yd; y_wr_n = v.yw; y_fwd_n = v.yf;
    endtask

    // Drive a request, idle one cycle, then sample after its result edge.
    task automatic run_vec(vec_t v);
        drive(v);
        @(negedge clk);
        set_idle();
        @(negedge clk);
        check_port("X", int'(v.req), x_vld, x_dout, v.exv, v.exd);
        check_port("Y", int'(v.req), y_vld, y_dout, v.eyv, v.eyd);
    endtask

    initial begin
        rst_n = 1'b0;
        x_oe_n = 1'b0; y_oe_n = 1'b0;
        x_addr = '0; y_addr = '0; x_din = '0; y_din = '0;
        set_idle();
        repeat (3) @(negedge clk);
        // R12: reset state
        check_port("X", 12, x_vld, x_dout, 1'b0, '0);
        check_port("Y", 12, y_vld, y_dout, 1'b0, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R11: output enable masks a valid read; falling enable shows it without a clock
        x_oe_n = 1'b1;
        drive('{1'b0,1'b1,10'd5,36'h0,1'b1,1'b1,10'd6,36'h0,1'b1,1'b1,
                1'b0,36'h0,1'b0,36'h0,8'd11});
        @(negedge clk);
        set_idle();
        @(negedge clk);
        check_port("X", 11, x_vld, x_dout, 1'b0, '0);
        check_port("Y", 11, y_vld, y_dout, 1'b1, 36'h0B2);
        x_oe_n = 1'b0;
        #1;
        check_port("X", 11, x_vld, x_dout, 1'b1, 36'h0C3);
        y_oe_n = 1'b1;
        #1;
        check_port("Y", 11, y_vld, y_dout, 1'b0, '0);
        y_oe_n = 1'b0;

        // R12: reset after a read clears outputs but not the array
        drive('{1'b0,1'b1,10'd9,36'h0,1'b1,1'b1,10'd7,36'h0,1'b1,1'b1,
                1'b0,36'h0,1'b0,36'h0,8'd12});
        @(negedge clk);
        set_idle();
        rst_n = 1'b0;
        @(negedge clk);
        check_port("X", 12, x_vld, x_dout, 1'b0, '0);
        check_port("Y", 12, y_vld, y_dout, 1'b0, '0);
        rst_n = 1'b1;
        run_vec('{1'b0,1'b1,10'd9,36'h0,1'b1,1'b1,10'd7,36'h0,1'b1,1'b1,
                  1'b1,36'h999,1'b1,36'h0E5,8'd12});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule